// File: doc/BRIEF.md
# Indexed Host Register Port with Mode Switch

This block is the host-facing front end of a synthesizer register file. A byte-wide host reaches an 11-bit register space through four ports: a status port, a data port and two index ports. After reset the block is in compatible mode. In this mode the two odd/even port pairs behave as a latched address and a data write, in two banks. A single compatible write to bank 1, address 0x05, with bit 7 set switches the block into native mode. In native mode ports 2 and 3 load the low and high bytes of a full 11-bit index, and port 1 reads or writes the register it selects.

Every accepted data write goes to downstream logic as a one-cycle strobe that carries the index and the byte. Native writes carry the de-aliased index. Compatible writes carry the raw bank and address. The block also stores the operator/key array and the small set of shared control registers, so the host can read them back. Several of these registers have irregular readback: bits that are never stored, a read-only register, and a register whose bits come back swapped.

Top module: `hostport_top`

## Requirements
- R1: After reset the block is in compatible mode, `rdData` is 0x00 and `regWrStrobe` is low. Every stored register reads 0x00, except byte offset 6 of each 8-byte operator slot in the array region, which reads 0x30.
- R2: A read of port 0 loads `statusIn` into `rdData` at the clock edge that samples `rdEn`, in either mode. `rdData` keeps its value while no read is made.
- R3: In compatible mode, a data write (port 1 or 3) to latched bank 1, address 0x05, with bit 7 set switches the block to native mode from the next cycle. The same write with bit 7 clear leaves the block in compatible mode. Bit 0 of such a write is kept as bit 0 of register 0x505.
- R4: In native mode, a port 2 write loads index bits 7:0 and a port 3 write loads index bits 10:8 from data bits 2:0, ignoring data bits 7:3. These writes never change the mode and never raise a strobe.
- R5: Any port 0 write in native mode returns the block to compatible mode. No stored register is cleared, and the native index is kept.
- R6: A native port 1 write to an implemented index raises `regWrStrobe` for exactly the following cycle, with `regWrCompat`=0, the index and the byte. The byte is stored for readback. Implemented indices are 0x000-0x253 (operator slots, then key registers), 0x402, 0x403, 0x404, 0x408, 0x4BD, 0x501, 0x504 and 0x505.
- R7: Indices 0x600-0x7FF alias 0x400-0x5FF for both reads and writes. The strobe reports the 0x400-0x5FF form.
- R8: A native read of an unimplemented index returns 0x00. A native write to one raises no strobe and stores nothing.
- R9: Register 0x505 ignores native writes, which raise no strobe. It reads back as bit 7 = 1, bits 6:1 = 0, and bit 0 as kept by R3.
- R10: Register 0x501 reads back with bits 0 and 5 exchanged: 0x01 reads as 0x20 and 0x20 reads as 0x01.
- R11: Bit 7 of 0x404 is passed on the strobe but never stored, and it reads as 0 (bits 6:0 are stored). Register 0x408 keeps only bit 6. Register 0x504 keeps only bits 5:0.
- R12: In compatible mode, a port 0 or port 2 write latches the address with bank 0 or bank 1 respectively. A port 1 or port 3 write raises a strobe with `regWrCompat`=1 and index {bank, address}. Writes to bank 0 addresses 0x02, 0x03, 0x04, 0x08 and 0xBD, and to bank 1 addresses 0x04 and 0x05, also update native 0x402, 0x403, 0x404, 0x408, 0x4BD, 0x504 and 0x505.
- R13: Port 1 reads in compatible mode, and port 2 or port 3 reads in either mode, return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| portAddr | input | 2 | Host port select |
| wrEn | input | 1 | Host write strobe |
| rdEn | input | 1 | Host read strobe |
| wrData | input | 8 | Host write byte |
| statusIn | input | 8 | Status byte returned by port 0 |
| rdData | output | 8 | Registered read byte |
| nativeMode | output | 1 | High while native mode is active |
| regWrStrobe | output | 1 | One-cycle downstream write pulse |
| regWrIndex | output | 11 | Index of the downstream write |
| regWrData | output | 8 | Byte of the downstream write |
| regWrCompat | output | 1 | Downstream write came from compatible mode |

## Verification
Every result of this block is due one clock edge after the host strobe that causes it. `rdData` takes its new value at the edge that samples `rdEn`. The strobe fields and `nativeMode` change at the edge that samples `wrEn`. The bench drives each strobe for one cycle starting at a falling edge and samples at the next falling edge, which lies half a period after the edge that produced the result. It then steps one more falling edge to confirm that a strobe has dropped again.

// File: rtl/hostport_pkg.sv
package hostport_pkg;
  localparam int IDX_W  = 11;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    PORT_STATUS = 2'd0,
    PORT_DATA   = 2'd1,
    PORT_IDX_LO = 2'd2,
    PORT_IDX_HI = 2'd3
  } port_e;

  typedef enum logic [1:0] {RD_ZERO, RD_STATUS, RD_REG} rdSel_e;

  typedef enum logic [3:0] {
    CL_NONE, CL_ARRAY, CL_TMR1, CL_TMR2, CL_TMRCTL,
    CL_CFG, CL_RHY, CL_TEST, CL_EXT, CL_MODE
  } regClass_e;

  // control -> datapath request bundle
  typedef struct packed {
    logic              natWr;
    logic              compWr;
    logic              rdReq;
    rdSel_e            rdSel;
    logic [IDX_W-1:0]  wrIdx;
    logic [IDX_W-1:0]  rdIdx;
    logic [DATA_W-1:0] data;
  } ctrlStrobe_t;

  localparam logic [IDX_W-1:0] IDX_TMR1   = 11'h402;
  localparam logic [IDX_W-1:0] IDX_TMR2   = 11'h403;
  localparam logic [IDX_W-1:0] IDX_TMRCTL = 11'h404;
  localparam logic [IDX_W-1:0] IDX_CFG    = 11'h408;
  localparam logic [IDX_W-1:0] IDX_RHY    = 11'h4BD;
  localparam logic [IDX_W-1:0] IDX_TEST   = 11'h501;
  localparam logic [IDX_W-1:0] IDX_EXT    = 11'h504;
  localparam logic [IDX_W-1:0] IDX_MODE   = 11'h505;
  localparam logic [IDX_W-1:0] IDX_VOID   = 11'h5FF;
  localparam logic [8:0]       COMP_ENTRY = 9'h105;

  // upper quarter of the space mirrors the one below it
  function automatic logic [IDX_W-1:0] unalias(input logic [IDX_W-1:0] idx);
    return (idx[10:9] == 2'b11) ? {2'b10, idx[8:0]} : idx;
  endfunction

  // native counterpart of a compatible-mode shared register
  function automatic logic [IDX_W-1:0] compatTarget(input logic bank, input logic [7:0] addr);
    logic [IDX_W-1:0] t;
    t = IDX_VOID;
    if (!bank) begin
      case (addr)
        8'h02:   t = IDX_TMR1;
        8'h03:   t = IDX_TMR2;
        8'h04:   t = IDX_TMRCTL;
        8'h08:   t = IDX_CFG;
        8'hBD:   t = IDX_RHY;
        default: t = IDX_VOID;
      endcase
    end else begin
      case (addr)
        8'h04:   t = IDX_EXT;
        8'h05:   t = IDX_MODE;
        default: t = IDX_VOID;
      endcase
    end
    return t;
  endfunction
endpackage

// File: rtl/hostport_ctrl.sv
module hostport_ctrl
  import hostport_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        portAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              nativeMode,
  output ctrlStrobe_t       strobe
);
  logic             nativeQ;
  logic [IDX_W-1:0] natIdxQ;
  logic             compBankQ;
  logic [7:0]       compAddrQ;
  port_e            port;

  assign port       = port_e'(portAddr);
  assign nativeMode = nativeQ;

  always_comb begin
    strobe        = '0;
    strobe.data   = wrData;
    strobe.rdIdx  = unalias(natIdxQ);
    strobe.wrIdx  = unalias(natIdxQ);
    strobe.rdReq  = rdEn;
    strobe.rdSel  = RD_ZERO;
    if (rdEn) begin
      case (port)
        PORT_STATUS: strobe.rdSel = RD_STATUS;
        PORT_DATA:   strobe.rdSel = nativeQ ? RD_REG : RD_ZERO;
        default:     strobe.rdSel = RD_ZERO;
      endcase
    end
    if (wrEn) begin
      if (nativeQ) begin
        strobe.natWr = (port == PORT_DATA);
      end else if (port == PORT_DATA || port == PORT_IDX_HI) begin
        strobe.compWr = 1'b1;
        strobe.wrIdx  = {2'b00, compBankQ, compAddrQ};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nativeQ   <= 1'b0;
      natIdxQ   <= '0;
      compBankQ <= 1'b0;
      compAddrQ <= '0;
    end else if (wrEn) begin
      if (nativeQ) begin
        case (port)
          PORT_STATUS: nativeQ <= 1'b0;
          PORT_IDX_LO: natIdxQ[7:0] <= wrData;
          PORT_IDX_HI: natIdxQ[10:8] <= wrData[2:0];
          default: ;
        endcase
      end else begin
        case (port)
          PORT_STATUS: begin compBankQ <= 1'b0; compAddrQ <= wrData; end
          PORT_IDX_LO: begin compBankQ <= 1'b1; compAddrQ <= wrData; end
          default:
            if ({compBankQ, compAddrQ} == COMP_ENTRY && wrData[7]) nativeQ <= 1'b1;
        endcase
      end
    end
  end

  // R5: a status-port write always leaves native mode
  assert_exit_native_R5: assert property (@(posedge clk) disable iff (!rstN)
    (nativeQ && wrEn && portAddr == 2'd0) |=> !nativeQ);

  // R3: the entry write switches modes on the following cycle
  assert_enter_native_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!nativeQ && wrEn && portAddr[0] && {compBankQ, compAddrQ} == COMP_ENTRY && wrData[7])
    |=> nativeQ);

  // R4: native index only moves on an index-port write
  assert_index_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (nativeQ && !(wrEn && portAddr[1])) |=> $stable(natIdxQ));
endmodule

// File: rtl/hostport_regs.sv
module hostport_regs
  import hostport_pkg::*;
#(
  parameter int              NUM_CH      = 18,
  parameter int              OPS_PER_CH  = 4,
  parameter int              REGS_PER_OP = 8,
  parameter int              NUM_KEY     = 20,
  parameter int              LR_REG_OFS  = 6,
  parameter logic [DATA_W-1:0] LR_RESET  = 8'h30
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] statusIn,
  output logic [DATA_W-1:0] rdData,
  output logic              regWrStrobe,
  output logic [IDX_W-1:0]  regWrIndex,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWrCompat
);
  localparam int ARRAY_OPS = NUM_CH * OPS_PER_CH * REGS_PER_OP;
  localparam int ARRAY_LEN = ARRAY_OPS + NUM_KEY;
  localparam int AW        = $clog2(ARRAY_LEN);
  localparam logic [IDX_W-1:0] ARRAY_END = IDX_W'(ARRAY_LEN);

  function automatic regClass_e classify(input logic [IDX_W-1:0] idx);
    if (idx < ARRAY_END) return CL_ARRAY;
    case (idx)
      IDX_TMR1:   return CL_TMR1;
      IDX_TMR2:   return CL_TMR2;
      IDX_TMRCTL: return CL_TMRCTL;
      IDX_CFG:    return CL_CFG;
      IDX_RHY:    return CL_RHY;
      IDX_TEST:   return CL_TEST;
      IDX_EXT:    return CL_EXT;
      IDX_MODE:   return CL_MODE;
      default:    return CL_NONE;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] resetByte(input int i);
    return (i < ARRAY_OPS && (i % REGS_PER_OP) == LR_REG_OFS) ? LR_RESET : '0;
  endfunction

  logic [DATA_W-1:0] arrayMem [ARRAY_LEN];
  logic [7:0] tmr1Q, tmr2Q, rhyQ, testQ;
  logic [6:0] tmrCtlQ;
  logic       cfgBitQ, modeLowQ;
  logic [5:0] extQ;

  logic [IDX_W-1:0] tgtIdx;
  regClass_e        tgtClass, natClass, rdClass;
  logic             doStore, fwdWr;
  logic [DATA_W-1:0] readVal;

  always_comb begin
    tgtIdx   = strobe.compWr ? compatTarget(strobe.wrIdx[8], strobe.wrIdx[7:0]) : strobe.wrIdx;
    tgtClass = classify(tgtIdx);
    natClass = classify(strobe.wrIdx);
    fwdWr    = strobe.compWr ||
               (strobe.natWr && natClass != CL_NONE && natClass != CL_MODE);
    doStore  = strobe.compWr || (strobe.natWr && tgtClass != CL_MODE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ARRAY_LEN; i++) arrayMem[i] <= resetByte(i);
    end else if (doStore && tgtClass == CL_ARRAY) begin
      arrayMem[tgtIdx[AW-1:0]] <= strobe.data;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmr1Q <= '0; tmr2Q <= '0; tmrCtlQ <= '0; cfgBitQ <= 1'b0;
      rhyQ <= '0; testQ <= '0; extQ <= '0; modeLowQ <= 1'b0;
    end else if (doStore) begin
      case (tgtClass)
        CL_TMR1:   tmr1Q    <= strobe.data;
        CL_TMR2:   tmr2Q    <= strobe.data;
        CL_TMRCTL: tmrCtlQ  <= strobe.data[6:0];
        CL_CFG:    cfgBitQ  <= strobe.data[6];
        CL_RHY:    rhyQ     <= strobe.data;
        CL_TEST:   testQ    <= strobe.data;
        CL_EXT:    extQ     <= strobe.data[5:0];
        CL_MODE:   modeLowQ <= strobe.data[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdClass = classify(strobe.rdIdx);
    case (rdClass)
      CL_ARRAY:  readVal = arrayMem[strobe.rdIdx[AW-1:0]];
      CL_TMR1:   readVal = tmr1Q;
      CL_TMR2:   readVal = tmr2Q;
      CL_TMRCTL: readVal = {1'b0, tmrCtlQ};
      CL_CFG:    readVal = {1'b0, cfgBitQ, 6'b0};
      CL_RHY:    readVal = rhyQ;
      CL_TEST:   readVal = {testQ[7:6], testQ[0], testQ[4:1], testQ[5]};
      CL_EXT:    readVal = {2'b00, extQ};
      CL_MODE:   readVal = {1'b1, 6'b0, modeLowQ};
      default:   readVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobe.rdReq) begin
      case (strobe.rdSel)
        RD_STATUS: rdData <= statusIn;
        RD_REG:    rdData <= readVal;
        default:   rdData <= '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regWrStrobe <= 1'b0;
      regWrIndex  <= '0;
      regWrData   <= '0;
      regWrCompat <= 1'b0;
    end else begin
      regWrStrobe <= fwdWr;
      if (fwdWr) begin
        regWrIndex  <= strobe.wrIdx;
        regWrData   <= strobe.data;
        regWrCompat <= strobe.compWr;
      end
    end
  end

  // R7: native strobes never carry an aliased index
  assert_no_alias_idx_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrStrobe && !regWrCompat) |-> (regWrIndex[10:9] != 2'b11));

  // R6: a strobe is always caused by a data write one cycle earlier
  assert_strobe_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    regWrStrobe |-> $past(strobe.natWr || strobe.compWr));

  // R11: the one-shot bit of the timer control never reads back
  assert_ctl_msb_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdReq && strobe.rdSel == RD_REG && strobe.rdIdx == IDX_TMRCTL) |=> !rdData[7]);

  // R9: mode register top bit reads as one; native writes are dropped
  assert_mode_msb_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdReq && strobe.rdSel == RD_REG && strobe.rdIdx == IDX_MODE) |=> rdData[7]);
  assert_mode_nowrite_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.natWr && strobe.wrIdx == IDX_MODE) |=> !regWrStrobe);

  // R8: unimplemented indices read as zero
  assert_void_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdReq && strobe.rdSel == RD_REG && classify(strobe.rdIdx) == CL_NONE) |=> rdData == '0);
endmodule

// File: rtl/hostport_top.sv
module hostport_top
  import hostport_pkg::*;
#(
  parameter int NUM_CH      = 18,
  parameter int OPS_PER_CH  = 4,
  parameter int REGS_PER_OP = 8,
  parameter int NUM_KEY     = 20
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  portAddr,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [7:0]  wrData,
  input  logic [7:0]  statusIn,
  output logic [7:0]  rdData,
  output logic        nativeMode,
  output logic        regWrStrobe,
  output logic [10:0] regWrIndex,
  output logic [7:0]  regWrData,
  output logic        regWrCompat
);
  ctrlStrobe_t strobe;

  hostport_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .portAddr(portAddr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .nativeMode(nativeMode), .strobe(strobe)
  );

  hostport_regs #(
    .NUM_CH(NUM_CH), .OPS_PER_CH(OPS_PER_CH),
    .REGS_PER_OP(REGS_PER_OP), .NUM_KEY(NUM_KEY)
  ) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .statusIn(statusIn),
    .rdData(rdData), .regWrStrobe(regWrStrobe), .regWrIndex(regWrIndex),
    .regWrData(regWrData), .regWrCompat(regWrCompat)
  );
endmodule

// File: tb/hostport_top_tb.sv
module hostport_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  portAddr = '0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]  wrData = '0, statusIn = '0;
  logic [7:0]  rdData;
  logic        nativeMode, regWrStrobe, regWrCompat;
  logic [10:0] regWrIndex;
  logic [7:0]  regWrData;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  hostport_top u_dut (
    .clk(clk), .rstN(rstN), .portAddr(portAddr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .statusIn(statusIn), .rdData(rdData), .nativeMode(nativeMode),
    .regWrStrobe(regWrStrobe), .regWrIndex(regWrIndex), .regWrData(regWrData),
    .regWrCompat(regWrCompat)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic portWr(input logic [1:0] p, input logic [7:0] d);
    @(negedge clk); portAddr = p; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic portRd(input logic [1:0] p, output logic [7:0] d);
    @(negedge clk); portAddr = p; rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0; d = rdData;
  endtask

  task automatic setIdx(input logic [10:0] i);
    portWr(2'd2, i[7:0]);
    portWr(2'd3, {5'b0, i[10:8]});
  endtask

  task automatic regRd(input logic [10:0] i, output logic [7:0] d);
    setIdx(i); portRd(2'd1, d);
  endtask

  task automatic regWr(input logic [10:0] i, input logic [7:0] d);
    setIdx(i); portWr(2'd1, d);
  endtask

  task automatic expRd(input logic [10:0] i, input logic [7:0] e, input string tag);
    logic [7:0] d;
    regRd(i, d);
    chk(d == e, tag, {8'h0, d}, {8'h0, e});
  endtask

  task automatic t_reset();
    chk(nativeMode == 1'b0, "R1 mode", {15'h0, nativeMode}, 16'h0);
    chk(rdData == 8'h00, "R1 rdData", {8'h0, rdData}, 16'h0);
    chk(regWrStrobe == 1'b0, "R1 strobe", {15'h0, regWrStrobe}, 16'h0);
  endtask

  task automatic t_status_reads();
    logic [7:0] d;
    statusIn = 8'hA5;
    portRd(2'd0, d);
    chk(d == 8'hA5, "R2 status compat", {8'h0, d}, 16'hA5);
    statusIn = 8'h3C;
    @(negedge clk);
    chk(rdData == 8'hA5, "R2 hold", {8'h0, rdData}, 16'hA5);
    portRd(2'd1, d);
    chk(d == 8'h00, "R13 data compat", {8'h0, d}, 16'h0);
    portRd(2'd3, d);
    chk(d == 8'h00, "R13 index port", {8'h0, d}, 16'h0);
  endtask

  task automatic t_compat_writes();
    portWr(2'd0, 8'h02);
    chk(regWrStrobe == 1'b0, "R12 addr latch no strobe", {15'h0, regWrStrobe}, 16'h0);
    portWr(2'd1, 8'h5A);
    chk(regWrStrobe && regWrCompat, "R12 strobe", {14'h0, regWrStrobe, regWrCompat}, 16'h3);
    chk(regWrIndex == 11'h002 && regWrData == 8'h5A, "R12 idx/data",
        {regWrIndex[7:0], regWrData}, 16'h025A);
    @(negedge clk);
    chk(regWrStrobe == 1'b0, "R12 one cycle", {15'h0, regWrStrobe}, 16'h0);
    portWr(2'd2, 8'h04);
    portWr(2'd3, 8'h3F);
    chk(regWrIndex == 11'h104, "R12 bank1 idx", {5'h0, regWrIndex}, 16'h104);
    portWr(2'd0, 8'hBD); portWr(2'd1, 8'h3C);
    portWr(2'd0, 8'h04); portWr(2'd1, 8'hE5);
  endtask

  task automatic t_entry();
    portWr(2'd2, 8'h05);
    portWr(2'd3, 8'h01);
    chk(nativeMode == 1'b0, "R3 no bit7 stays compat", {15'h0, nativeMode}, 16'h0);
    chk(regWrIndex == 11'h105 && regWrCompat, "R3 compat strobe", {5'h0, regWrIndex}, 16'h105);
    portWr(2'd3, 8'h81);
    chk(nativeMode == 1'b1, "R3 enter native", {15'h0, nativeMode}, 16'h1);
  endtask

  task automatic t_native_index();
    portWr(2'd2, 8'h05);
    portWr(2'd3, 8'h80);
    chk(regWrStrobe == 1'b0, "R4 index write no strobe", {15'h0, regWrStrobe}, 16'h0);
    chk(nativeMode == 1'b1, "R4 mode kept", {15'h0, nativeMode}, 16'h1);
    expRd(11'h006, 8'h30, "R1 lr reset");
    expRd(11'h23D, 8'h00, "R1 zero reset");
    portWr(2'd2, 8'h3E);
    portWr(2'd3, 8'hFA);
    begin
      logic [7:0] d;
      portRd(2'd1, d);
      chk(d == 8'h30, "R4 high bits ignored", {8'h0, d}, 16'h30);
    end
  endtask

  task automatic t_native_write();
    regWr(11'h123, 8'h77);
    chk(regWrStrobe && !regWrCompat, "R6 strobe", {14'h0, regWrStrobe, regWrCompat}, 16'h2);
    chk(regWrIndex == 11'h123 && regWrData == 8'h77, "R6 idx/data",
        {regWrIndex[7:0], regWrData}, 16'h2377);
    @(negedge clk);
    chk(regWrStrobe == 1'b0, "R6 one cycle", {15'h0, regWrStrobe}, 16'h0);
    expRd(11'h123, 8'h77, "R6 readback");
    regWr(11'h253, 8'h03);
    expRd(11'h253, 8'h03, "R6 key reg");
    expRd(11'h505, 8'h81, "R9 bit0 from entry");
    expRd(11'h402, 8'h5A, "R12 shared 0x402");
    expRd(11'h504, 8'h3F, "R12 shared 0x504");
    expRd(11'h4BD, 8'h3C, "R12 shared 0x4BD");
    expRd(11'h404, 8'h65, "R11 compat bit7 dropped");
  endtask

  task automatic t_alias();
    regWr(11'h6BD, 8'h11);
    chk(regWrIndex == 11'h4BD, "R7 strobe idx", {5'h0, regWrIndex}, 16'h4BD);
    expRd(11'h4BD, 8'h11, "R7 write alias");
    expRd(11'h602, 8'h5A, "R7 read alias");
  endtask

  task automatic t_void();
    regWr(11'h300, 8'h99);
    chk(regWrStrobe == 1'b0, "R8 no strobe", {15'h0, regWrStrobe}, 16'h0);
    expRd(11'h300, 8'h00, "R8 read zero");
    regWr(11'h254, 8'h55);
    chk(regWrStrobe == 1'b0, "R8 past key regs", {15'h0, regWrStrobe}, 16'h0);
    expRd(11'h254, 8'h00, "R8 read past key");
  endtask

  task automatic t_irregular();
    regWr(11'h505, 8'h00);
    chk(regWrStrobe == 1'b0, "R9 write dropped", {15'h0, regWrStrobe}, 16'h0);
    expRd(11'h505, 8'h81, "R9 unchanged");
    regWr(11'h501, 8'h01);
    expRd(11'h501, 8'h20, "R10 0x01");
    regWr(11'h501, 8'h20);
    expRd(11'h501, 8'h01, "R10 0x20");
    regWr(11'h404, 8'hE3);
    chk(regWrData == 8'hE3, "R11 strobe keeps bit7", {8'h0, regWrData}, 16'hE3);
    expRd(11'h404, 8'h63, "R11 bit7 reads 0");
    regWr(11'h408, 8'hFF);
    expRd(11'h408, 8'h40, "R11 0x408");
    regWr(11'h504, 8'hFF);
    expRd(11'h504, 8'h3F, "R11 0x504");
  endtask

  task automatic t_exit();
    logic [7:0] d;
    portWr(2'd0, 8'h00);
    chk(nativeMode == 1'b0, "R5 exit", {15'h0, nativeMode}, 16'h0);
    chk(regWrStrobe == 1'b0, "R5 no strobe", {15'h0, regWrStrobe}, 16'h0);
    portRd(2'd1, d);
    chk(d == 8'h00, "R13 data after exit", {8'h0, d}, 16'h0);
    portWr(2'd2, 8'h05);
    portWr(2'd3, 8'h80);
    chk(nativeMode == 1'b1, "R3 reenter", {15'h0, nativeMode}, 16'h1);
    expRd(11'h123, 8'h77, "R5 retained");
    expRd(11'h505, 8'h80, "R9 bit0 cleared");
    statusIn = 8'h5C;
    portRd(2'd0, d);
    chk(d == 8'h5C, "R2 status native", {8'h0, d}, 16'h5C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_status_reads();
    t_compat_writes();
    t_entry();
    t_native_index();
    t_native_write();
    t_alias();
    t_void();
    t_irregular();
    t_exit();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual 0x1 expected 0x0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule